// File: doc/BRIEF.md
# Core Event Controller with Automatic Status Stacking

This block sits beside a processor's instruction sequencer. It gathers core events on one request vector: arithmetic faults, circular-buffer faults, requests forwarded from the system-level controller, a debug event and a software-raised event. Each request is held in a pending latch. The latch is gated by a software-written enable register. The lowest-numbered event that is pending and enabled is chosen and the sequencer is sent to it through a one-cycle take strobe and a vector index.

When an event is taken, the live values of the two arithmetic status words and the mode word are pushed onto a small hardware stack at the same clock edge. The handler therefore needs no save sequence. A return pulse pops the top entry, presents the three words to the sequencer for restore and retires the event that was entered most recently. Nesting is allowed only for an event of strictly higher priority than every event already in service. If the stack is full, the entry is refused and a sticky error flag is raised.

There is no streaming data path. Every pin is a plain level or pulse control signal, and none is subject to back-pressure. The sequencer must accept the take strobe and the restore strobe in the cycle they appear.

Top module: `core_evt_ctl`

## Requirements
- R1: After reset the pending vector, the in-service vector, the enable register, the take strobe, the restore strobe and the overflow flag are all zero.
- R2: A request bit that is high at a clock edge sets its pending bit. A pending bit whose enable bit is zero stays set and is never taken.
- R3: When at least one pending bit is enabled, the take strobe is high for exactly one cycle, beginning at the clock edge after the edge at which that pending bit became visible with its enable set. The vector index gives the lowest-numbered enabled pending bit, and bit 0 has the highest priority.
- R4: At the edge that raises the take strobe, the pending bit of the taken event clears and its in-service bit sets.
- R5: While events are in service, a new event is taken only if its index is lower than the lowest in-service index. Events of lower or equal priority stay pending.
- R6: At the edge that raises the take strobe, the current values of both arithmetic status inputs and the mode input are pushed onto the status stack.
- R7: A return pulse with a non-empty stack pops the top entry. One edge later the restore strobe is high for one cycle and the restore outputs carry the popped words, last in first out. The lowest-numbered in-service bit is cleared, and no event is taken at the edge where the return pulse is sampled.
- R8: The stack holds 8 entries. An event that would be taken while all 8 entries are used is refused and stays pending. The overflow flag then sets and remains set until reset.
- R9: A software clear bit clears its pending bit. When a request and a clear for the same bit occur at the same edge, the clear wins.
- R10: A return pulse with an empty stack changes neither the in-service vector nor the restore strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_req_i | input | 16 | Event request vector, bit 0 is the highest priority |
| sw_clr_i | input | 16 | Software clear of pending bits |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wd_i | input | 16 | New value of the enable register |
| astx_i | input | 32 | Live arithmetic status word, first element |
| asty_i | input | 32 | Live arithmetic status word, second element |
| mode_i | input | 32 | Live mode word |
| rti_i | input | 1 | Return-from-handler pulse |
| take_o | output | 1 | One-cycle strobe: enter a handler |
| vec_o | output | 4 | Index of the event being entered |
| pend_o | output | 16 | Pending vector |
| isr_o | output | 16 | In-service vector |
| ovf_o | output | 1 | Sticky status stack overflow flag |
| rest_vld_o | output | 1 | One-cycle strobe: restore the words below |
| rest_astx_o | output | 32 | Restored first arithmetic status word |
| rest_asty_o | output | 32 | Restored second arithmetic status word |
| rest_mode_o | output | 32 | Restored mode word |

## Verification
A stack pointer that drifts away from the in-service vector first shows up at a return. The restore outputs then carry the words of a different entry, or the restore strobe fails to fire, in the cycle after the pulse. A wrong priority choice or nesting decision shows on the vector index one edge after the pending bit appears, and a pending bit that was lost or cleared too early shows at once on the pending vector. Overflow errors show on the flag at the ninth nested entry, which is why the tests nest to full depth and then unwind every level.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int EVT_N  = 16;
  localparam int STAT_W = 32;
  localparam int STK_D  = 8;

  typedef struct packed {
    logic [STAT_W-1:0] astx;
    logic [STAT_W-1:0] asty;
    logic [STAT_W-1:0] mode;
  } stat_t;
endpackage

// File: rtl/evt_pick.sv
module evt_pick #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/evt_pend.sv
module evt_pend #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_i,
  input  logic [N-1:0]  clr_i,
  input  logic          take_i,
  input  logic [IW-1:0] take_idx_i,
  input  logic          en_we_i,
  input  logic [N-1:0]  en_wd_i,
  output logic [N-1:0]  pend_o,
  output logic [N-1:0]  en_o
);
  logic [N-1:0] pend_q, en_q, take_clr;

  always_comb begin
    take_clr = '0;
    if (take_i) take_clr[take_idx_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q | set_i) & ~clr_i & ~take_clr;
      if (en_we_i) en_q <= en_wd_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;

  // R9: a software clear always wins over a request at the same edge
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i != '0 |=> (pend_q & $past(clr_i)) == '0);
endmodule

// File: rtl/evt_stack.sv
module evt_stack #(
  parameter int D  = 8,
  localparam int CW = $clog2(D + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  evt_pkg::stat_t    din_i,
  input  logic              pop_i,
  output logic [CW-1:0]     cnt_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              rest_vld_o,
  output evt_pkg::stat_t    rest_o
);
  evt_pkg::stat_t mem [D];
  logic [CW-1:0]  cnt_q;
  evt_pkg::stat_t rest_q;
  logic           rest_vld_q;
  logic           do_push, do_pop;

  assign full_o  = (cnt_q == CW'(D));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o && !push_i;

  always_ff @(posedge clk) begin
    if (do_push) mem[cnt_q[CW-2:0]] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      rest_q     <= '0;
      rest_vld_q <= 1'b0;
    end else begin
      rest_vld_q <= do_pop;
      if (do_push) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (do_pop) begin
        cnt_q  <= cnt_q - 1'b1;
        rest_q <= mem[cnt_q[CW-2:0] - 1'b1];
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign rest_vld_o = rest_vld_q;
  assign rest_o     = rest_q;

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(D));
  p_push_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> cnt_q == $past(cnt_q) + 1'b1);
  p_pop_restores_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !empty_o && !push_i) |=> rest_vld_q);
endmodule

// File: rtl/core_evt_ctl.sv
module core_evt_ctl #(
  parameter int N_EVT = evt_pkg::EVT_N,
  parameter int SW    = evt_pkg::STAT_W,
  parameter int DEPTH = evt_pkg::STK_D,
  localparam int IW   = $clog2(N_EVT),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_req_i,
  input  logic [N_EVT-1:0] sw_clr_i,
  input  logic             en_we_i,
  input  logic [N_EVT-1:0] en_wd_i,
  input  logic [SW-1:0]    astx_i,
  input  logic [SW-1:0]    asty_i,
  input  logic [SW-1:0]    mode_i,
  input  logic             rti_i,
  output logic             take_o,
  output logic [IW-1:0]    vec_o,
  output logic [N_EVT-1:0] pend_o,
  output logic [N_EVT-1:0] isr_o,
  output logic             ovf_o,
  output logic             rest_vld_o,
  output logic [SW-1:0]    rest_astx_o,
  output logic [SW-1:0]    rest_asty_o,
  output logic [SW-1:0]    rest_mode_o
);
  logic [N_EVT-1:0] pend, en, isr_q;
  logic             c_any, i_any;
  logic [IW-1:0]    c_idx, i_idx;
  logic             want, take, pop, full, empty;
  logic [CW-1:0]    stk_cnt;
  logic             take_q, ovf_q;
  logic [IW-1:0]    vec_q;
  evt_pkg::stat_t   push_d, rest;

  evt_pend #(.N(N_EVT)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(evt_req_i), .clr_i(sw_clr_i),
    .take_i(take), .take_idx_i(c_idx), .en_we_i(en_we_i), .en_wd_i(en_wd_i),
    .pend_o(pend), .en_o(en)
  );

  evt_pick #(.N(N_EVT)) u_pick_cand (.vec_i(pend & en), .any_o(c_any), .idx_o(c_idx));
  evt_pick #(.N(N_EVT)) u_pick_isr  (.vec_i(isr_q),     .any_o(i_any), .idx_o(i_idx));

  // nest only above every event in service; never on a return edge
  assign want = c_any && (!i_any || (c_idx < i_idx)) && !rti_i;
  assign take = want && !full;
  assign pop  = rti_i && !empty;

  assign push_d = '{astx: astx_i, asty: asty_i, mode: mode_i};

  evt_stack #(.D(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_i(take), .din_i(push_d), .pop_i(pop),
    .cnt_o(stk_cnt), .full_o(full), .empty_o(empty),
    .rest_vld_o(rest_vld_o), .rest_o(rest)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      take_q <= 1'b0;
      vec_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      take_q <= take;
      if (take) vec_q <= c_idx;
      if (want && full) ovf_q <= 1'b1;
      if (take)     isr_q[c_idx] <= 1'b1;
      else if (pop) isr_q[i_idx] <= 1'b0;
    end
  end

  assign take_o      = take_q;
  assign vec_o       = vec_q;
  assign pend_o      = pend;
  assign isr_o       = isr_q;
  assign ovf_o       = ovf_q;
  assign rest_astx_o = rest.astx;
  assign rest_asty_o = rest.asty;
  assign rest_mode_o = rest.mode;

  p_taken_in_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> isr_q[vec_q]);
  p_isr_matches_stack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr_q) == int'(stk_cnt));
  p_no_take_on_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rti_i |=> !take_q);
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
endmodule

// File: tb/core_evt_ctl_bench.sv
module core_evt_ctl_bench;
  localparam int N = 16;
  localparam int W = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] evt_req, sw_clr, en_wd, pend, isr;
  logic         en_we, rti, take, ovf, rest_vld;
  logic [W-1:0] astx, asty, mode, r_astx, r_asty, r_mode;
  logic [3:0]   vec;

  int n_chk = 0;
  int n_bad = 0;

  core_evt_ctl u_core_evt_ctl (
    .clk(clk), .rst_n(rst_n), .evt_req_i(evt_req), .sw_clr_i(sw_clr),
    .en_we_i(en_we), .en_wd_i(en_wd), .astx_i(astx), .asty_i(asty),
    .mode_i(mode), .rti_i(rti), .take_o(take), .vec_o(vec), .pend_o(pend),
    .isr_o(isr), .ovf_o(ovf), .rest_vld_o(rest_vld), .rest_astx_o(r_astx),
    .rest_asty_o(r_asty), .rest_mode_o(r_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask
  task automatic pulse_evt(input logic [N-1:0] v); evt_req = v; tick(); evt_req = '0; endtask
  task automatic set_en(input logic [N-1:0] v); en_we = 1'b1; en_wd = v; tick(); en_we = 1'b0; endtask
  task automatic do_rti; rti = 1'b1; tick(); rti = 1'b0; endtask
  task automatic set_stat(input logic [W-1:0] x); astx = x; asty = x ^ 32'h00FF_00FF; mode = ~x; endtask

  task automatic t_reset;
    chk("R1 pend", pend, 0); chk("R1 isr", isr, 0); chk("R1 take", take, 0);
    chk("R1 ovf", ovf, 0); chk("R1 rest_vld", rest_vld, 0);
  endtask

  task automatic t_masked;
    pulse_evt(16'h0008);
    chk("R2 latched", pend, 16'h0008);
    for (int i = 0; i < 3; i++) begin tick(); chk("R2 masked no take", take, 0); end
    chk("R2 still pending", pend, 16'h0008);
  endtask

  task automatic t_unmask;
    set_stat(32'hA1A1_0001);
    set_en(16'h0008);
    chk("R3 not yet", take, 0);
    tick();
    chk("R3 take", take, 1); chk("R3 vec", vec, 3);
    chk("R4 pend cleared", pend, 0); chk("R4 isr set", isr, 16'h0008);
    tick();
    chk("R3 one cycle", take, 0);
  endtask

  task automatic t_return;
    set_stat(32'h5555_5555);
    do_rti();
    chk("R7 rest_vld", rest_vld, 1); chk("R6 astx", r_astx, 32'hA1A1_0001);
    chk("R6 asty", r_asty, 32'hA1A1_0001 ^ 32'h00FF_00FF);
    chk("R6 mode", r_mode, ~32'hA1A1_0001); chk("R7 isr", isr, 0);
    tick();
    chk("R7 rest one cycle", rest_vld, 0);
  endtask

  task automatic t_priority;
    set_en('1);
    set_stat(32'h50);
    pulse_evt(16'h0220);
    tick();
    chk("R3 prio take", take, 1); chk("R3 prio vec", vec, 5);
    tick();
    chk("R5 no lower nest", take, 0); chk("R5 lower pending", pend, 16'h0200);
    set_stat(32'h90);
    do_rti();
    chk("R7 no take on return", take, 0); chk("R7 isr cleared", isr, 0);
    tick();
    chk("R3 next take", take, 1); chk("R3 next vec", vec, 9);
  endtask

  task automatic t_nest;
    set_stat(32'h20);
    pulse_evt(16'h0004);
    tick();
    chk("R5 nest take", take, 1); chk("R5 nest vec", vec, 2); chk("R5 isr", isr, 16'h0204);
    do_rti();
    chk("R7 lifo inner", r_astx, 32'h20); chk("R7 isr inner", isr, 16'h0200);
    do_rti();
    chk("R7 lifo outer", r_astx, 32'h90); chk("R7 isr outer", isr, 0);
  endtask

  task automatic t_clear;
    set_en('0);
    pulse_evt(16'h0010);
    chk("R9 pending", pend, 16'h0010);
    sw_clr = 16'h0010; tick(); sw_clr = '0;
    chk("R9 cleared", pend, 0);
    evt_req = 16'h0040; sw_clr = 16'h0040; tick(); evt_req = '0; sw_clr = '0;
    chk("R9 clear wins", pend, 0);
  endtask

  task automatic t_overflow;
    set_en('1);
    chk("R8 ovf clear before", ovf, 0);
    for (int k = 15; k >= 8; k--) begin
      set_stat(32'(k));
      pulse_evt(16'(1 << k));
      tick();
      chk("R8 fill take", take, 1); chk("R8 fill vec", 32'(vec), 32'(k));
    end
    chk("R8 isr full", isr, 16'hFF00);
    pulse_evt(16'h0080);
    tick();
    chk("R8 refused", take, 0); chk("R8 ovf set", ovf, 1);
    chk("R8 stays pending", pend, 16'h0080);
    set_en('0);
    sw_clr = 16'h0080; tick(); sw_clr = '0;
    for (int i = 0; i < 8; i++) begin
      do_rti();
      chk("R7 unwind", r_astx, 32'(8 + i));
    end
    chk("R7 isr empty", isr, 0); chk("R8 ovf sticky", ovf, 1);
  endtask

  task automatic t_empty_rti;
    do_rti();
    chk("R10 no restore", rest_vld, 0); chk("R10 isr", isr, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_req = '0; sw_clr = '0; en_we = 1'b0; en_wd = '0;
    rti = 1'b0; set_stat('0);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_masked();
    t_unmask();
    t_return();
    t_priority();
    t_nest();
    t_clear();
    t_overflow();
    t_empty_rti();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule